// File: doc/BRIEF.md
# External Pin Interrupt Sense Controller

This block watches two external interrupt pins and turns their activity into interrupt requests for the processor's interrupt logic. One two-bit sense field, shared by both pins, chooses what counts as an event: a held low level, any change, a falling edge or a rising edge. Each pin has its own enable bit in a mask register. A global enable input gates both requests.

Pins are brought into the clock domain through a synchroniser before any edge is detected. Edge-type events set a sticky pending flag per pin, which the interrupt logic clears with a one-cycle acknowledge. Level events are not stored: a level request lasts only while the pin stays low. A separate wake output is built from the raw pins with no clock in its path, so a held low level can restart a stopped clock. If the pin returns high before the synchronised sample sees it, the system wakes but no request follows. A small register port writes and reads the sense and mask registers.

Top module: `extIntSense`

## Requirements
- R1: After reset the sense field is 00, both mask enables are 0, `irq` is 00 and `wake` is 0.
- R2: With `regSel`=0 the sense field is bits 1:0 and the other bits read 0. With `regSel`=1 the pin-1 enable is bit 7 and the pin-0 enable is bit 6. Bits 5:0 of the mask register read 0, and writes to them have no effect.
- R3: The sense encoding applies to both pins: 00 is low level, 01 is any change, 10 is a falling edge and 11 is a rising edge.
- R4: An edge event reaches `irq` after the third rising clock edge that follows the pin change (two synchroniser flops, then the history flop). A pulse that lasts longer than one clock period always produces the request.
- R5: `irq[i]` is 1 only when the pin's mask bit and `globalIe` are both 1. Edge pending flags still set while they are gated, and they appear as soon as the gating opens.
- R6: An edge pending flag stays set until `ack[i]` is sampled high at a rising edge, which clears it. An edge detected in that same cycle wins over the clear.
- R7: Writing a sense value that differs from the current one clears both pending flags.
- R8: In low-level mode `irq[i]` follows the synchronised pin, two clock edges behind it, and drops once the pin is high again. Nothing is latched.
- R9: `wake` is combinational. It is 1 when the sense field is low level and any enabled pin is low, and it needs no clock edge. A low pulse that ends before being sampled raises `wake` but never `irq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| pinIn | input | 2 | External interrupt pins, asynchronous |
| globalIe | input | 1 | Global interrupt enable |
| ack | input | 2 | Per-pin acknowledge pulse that clears a pending flag |
| regWrEn | input | 1 | Register write strobe |
| regSel | input | 1 | 0 selects the sense register, 1 selects the mask register |
| regWrData | input | 8 | Write data |
| regRdData | output | 8 | Read data for the selected register |
| irq | output | 2 | Per-pin interrupt request |
| wake | output | 1 | Asynchronous wake request |

## Verification
The bench aims at the places where a plausible design goes wrong.
- **Wrong edge polarity or shared field per pin.** A design that decodes the sense encoding wrongly, or applies it to only one pin, gives a request for the wrong edge or misses pin 1.
- **Pending flag handling.** A flag that is gated rather than stored loses requests raised while the global enable is off. A flag that ignores a mode write fires falsely after the switch.
- **Latched low level.** A latched level request stays high after the pin is released.
- **Clocked wake.** A clocked wake path misses a sub-cycle low pulse. A wake path tied into the request path raises `irq` for that pulse.

Register masking is checked by writing all ones and reading back.

// File: rtl/extIntPkg.sv
package extIntPkg;
  parameter int unsigned PIN_COUNT = 2;

  typedef enum logic [1:0] {
    SENSE_LOW  = 2'b00,
    SENSE_ANY  = 2'b01,
    SENSE_FALL = 2'b10,
    SENSE_RISE = 2'b11
  } senseMode_e;

  // control -> datapath strobes
  typedef struct packed {
    senseMode_e             mode;
    logic                   modeChange;
    logic [PIN_COUNT-1:0]   maskEn;
    logic [PIN_COUNT-1:0]   ackClr;
  } ctrlStrobe_t;
endpackage

// File: rtl/extIntCtrl.sv
module extIntCtrl
  import extIntPkg::*;
#(
  parameter int unsigned DATA_W = 8,
  parameter int unsigned EN_LSB = 6
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 regWrEn,
  input  logic                 regSel,
  input  logic [DATA_W-1:0]    regWrData,
  input  logic [PIN_COUNT-1:0] ack,
  output logic [DATA_W-1:0]    regRdData,
  output ctrlStrobe_t          strobe
);
  localparam int unsigned MODE_W = $bits(senseMode_e);

  senseMode_e           modeQ;
  logic [PIN_COUNT-1:0] maskQ;
  senseMode_e           modeWr;
  logic                 wrMode;
  logic                 wrMask;

  assign modeWr = senseMode_e'(regWrData[MODE_W-1:0]);
  assign wrMode = regWrEn && !regSel;
  assign wrMask = regWrEn && regSel;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= SENSE_LOW;
      maskQ <= '0;
    end else begin
      if (wrMode) modeQ <= modeWr;
      if (wrMask) maskQ <= regWrData[EN_LSB +: PIN_COUNT];
    end
  end

  always_comb begin
    regRdData = '0;
    if (regSel) regRdData[EN_LSB +: PIN_COUNT] = maskQ;
    else        regRdData[MODE_W-1:0]          = modeQ;
  end

  always_comb begin
    strobe.mode       = modeQ;
    strobe.modeChange = wrMode && (modeWr != modeQ);
    strobe.maskEn     = maskQ;
    strobe.ackClr     = ack;
  end
endmodule

// File: rtl/extIntPath.sv
module extIntPath
  import extIntPkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [PIN_COUNT-1:0] pinIn,
  input  logic                 globalIe,
  input  ctrlStrobe_t          strobe,
  output logic [PIN_COUNT-1:0] irq,
  output logic                 wake
);
  localparam int unsigned LAST = SYNC_STAGES - 1;

  // unclocked wake from raw pins
  assign wake = (strobe.mode == SENSE_LOW) && |(strobe.maskEn & ~pinIn);

  for (genvar g = 0; g < PIN_COUNT; g++) begin : gPin
    logic [SYNC_STAGES-1:0] syncQ;
    logic                   prevQ;
    logic                   pendQ;
    logic                   sampled;
    logic                   hit;
    logic                   raw;

    assign sampled = syncQ[LAST];

    always_comb begin
      unique case (strobe.mode)
        SENSE_ANY:  hit = sampled ^ prevQ;
        SENSE_FALL: hit = prevQ & ~sampled;
        SENSE_RISE: hit = ~prevQ & sampled;
        default:    hit = 1'b0;
      endcase
    end

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        syncQ <= '1;
        prevQ <= 1'b1;
        pendQ <= 1'b0;
      end else begin
        if (SYNC_STAGES > 1) syncQ <= {syncQ[SYNC_STAGES-2:0], pinIn[g]};
        else                 syncQ <= pinIn[g];
        prevQ <= sampled;
        if (strobe.modeChange) pendQ <= 1'b0;
        else                   pendQ <= hit | (pendQ & ~strobe.ackClr[g]);
      end
    end

    assign raw    = (strobe.mode == SENSE_LOW) ? ~sampled : pendQ;
    assign irq[g] = raw & strobe.maskEn[g] & globalIe;
  end
endmodule

// File: rtl/extIntSense.sv
module extIntSense
  import extIntPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] pinIn,
  input  logic       globalIe,
  input  logic [1:0] ack,
  input  logic       regWrEn,
  input  logic       regSel,
  input  logic [7:0] regWrData,
  output logic [7:0] regRdData,
  output logic [1:0] irq,
  output logic       wake
);
  ctrlStrobe_t strobe;
  logic [1:0]  senseMode;
  logic [1:0]  maskEn;

  assign senseMode = strobe.mode;
  assign maskEn    = strobe.maskEn;

  extIntCtrl #(.DATA_W(8), .EN_LSB(6)) ctrlI (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel),
    .regWrData(regWrData), .ack(ack), .regRdData(regRdData), .strobe(strobe)
  );

  extIntPath #(.SYNC_STAGES(2)) pathI (
    .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIe(globalIe),
    .strobe(strobe), .irq(irq), .wake(wake)
  );
endmodule

// File: rtl/extIntSense_chk.sv
module extIntSense_chk (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] pinIn,
  input logic       globalIe,
  input logic [1:0] ack,
  input logic [1:0] irq,
  input logic       wake,
  input logic [1:0] senseMode,
  input logic [1:0] maskEn
);
  // R5
  gie_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    !globalIe |-> (irq == 2'b00));
  // R5
  mask0_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq[0] |-> maskEn[0]);
  // R5
  mask1_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq[1] |-> maskEn[1]);
  // R9
  wake_pin_chk: assert property (@(posedge clk) disable iff (!rstN)
    wake |-> (pinIn != 2'b11 && senseMode == 2'b00));
  // R6
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (senseMode != 2'b00 && irq[0] && !ack[0])
      |=> (irq[0] || !globalIe || !maskEn[0] || !$stable(senseMode)));
endmodule

bind extIntSense extIntSense_chk chkI (
  .clk(clk), .rstN(rstN), .pinIn(pinIn), .globalIe(globalIe), .ack(ack),
  .irq(irq), .wake(wake), .senseMode(senseMode), .maskEn(maskEn)
);

// File: tb/tb_extIntSense.sv
module tb_extIntSense;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] pinIn = 2'b11;
  logic       globalIe = 1'b0;
  logic [1:0] ack = 2'b00;
  logic       regWrEn = 1'b0;
  logic       regSel = 1'b0;
  logic [7:0] regWrData = '0;
  logic [7:0] regRdData;
  logic [1:0] irq;
  logic       wake;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  extIntSense dut (.*);

  // {mode[1:0], startLevel, endLevel, expected irq[0]}
  localparam logic [4:0] VEC [9] = '{
    5'b01_0_1_1, 5'b01_1_0_1, 5'b01_1_1_0,
    5'b10_1_0_1, 5'b10_0_1_0,
    5'b11_0_1_1, 5'b11_1_0_0,
    5'b00_1_0_1, 5'b00_0_1_0
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic sel, input logic [7:0] d);
    regSel = sel; regWrData = d; regWrEn = 1'b1;
    tick(1);
    regWrEn = 1'b0;
  endtask

  task automatic pulseAck(input logic [1:0] a);
    ack = a; tick(1); ack = 2'b00;
  endtask

  initial begin
    tick(2);
    rstN = 1'b1;
    tick(1);
    // R1 reset state
    regSel = 1'b0; #1 chk("R1 sense", regRdData, 8'h00);
    regSel = 1'b1; #1 chk("R1 mask", regRdData, 8'h00);
    chk("R1 irq", {6'b0, irq}, 8'h00);
    chk("R1 wake", {7'b0, wake}, 8'h00);
    tick(1);

    globalIe = 1'b1;
    wr(1'b1, 8'hC0);
    for (int i = 0; i < 9; i++) begin
      wr(1'b0, {6'b0, VEC[i][4:3]});
      pinIn[0] = VEC[i][2];
      tick(4);
      pulseAck(2'b01);
      pinIn[0] = VEC[i][1];
      tick(3);
      if (VEC[i][4:3] == 2'b00) chk("R8 level vector", {7'b0, irq[0]}, {7'b0, VEC[i][0]});
      else                      chk("R3 edge vector", {7'b0, irq[0]}, {7'b0, VEC[i][0]});
    end

    // R3/R4 shared rising sense on both pins
    wr(1'b0, 8'h03);
    pinIn = 2'b00; tick(4); pulseAck(2'b11);
    pinIn = 2'b11; tick(2);
    chk("R4 not yet after two edges", {6'b0, irq}, 8'h00);
    tick(1);
    chk("R3 both pins rise", {6'b0, irq}, 8'h03);

    // R6 ack clears only its pin
    pulseAck(2'b01);
    chk("R6 ack pin0", {6'b0, irq}, 8'h02);

    // R7 mode change clears pending
    wr(1'b0, 8'h02);
    chk("R7 mode change", {6'b0, irq}, 8'h00);

    // R5 gated pending retained
    globalIe = 1'b0;
    pinIn = 2'b00; tick(3);
    chk("R5 gie off", {6'b0, irq}, 8'h00);
    globalIe = 1'b1; #1
    chk("R5 gie on", {6'b0, irq}, 8'h03);

    // R5 mask gating
    pulseAck(2'b11);
    wr(1'b1, 8'h40);
    pinIn = 2'b11; tick(3);
    pinIn = 2'b00; tick(3);
    chk("R5 pin1 masked", {6'b0, irq}, 8'h01);
    wr(1'b1, 8'hC0);
    chk("R5 pin1 unmasked", {6'b0, irq}, 8'h03);

    // R4 pulse longer than a clock
    pulseAck(2'b11);
    wr(1'b0, 8'h03);
    pinIn[0] = 1'b1; tick(2);
    pinIn[0] = 1'b0; tick(3);
    chk("R4 two-cycle pulse", {7'b0, irq[0]}, 8'h01);

    // R8 low level not latched
    wr(1'b0, 8'h00);
    chk("R8 level low", {6'b0, irq}, 8'h03);
    chk("R9 wake on low", {7'b0, wake}, 8'h01);
    pinIn[0] = 1'b1; tick(2);
    chk("R8 released", {6'b0, irq}, 8'h02);

    // R9 sub-cycle pulse wakes without request
    pinIn[1] = 1'b1; tick(3);
    chk("R9 idle wake", {7'b0, wake}, 8'h00);
    #1 pinIn[0] = 1'b0;
    #1 chk("R9 async wake", {7'b0, wake}, 8'h01);
    #1 pinIn[0] = 1'b1;
    #1 chk("R9 wake drops", {7'b0, wake}, 8'h00);
    tick(3);
    chk("R9 no irq", {6'b0, irq}, 8'h00);

    // R2 register field masking
    wr(1'b0, 8'hFF);
    regSel = 1'b0; #1 chk("R2 sense readback", regRdData, 8'h03);
    tick(1);
    wr(1'b1, 8'hFF);
    regSel = 1'b1; #1 chk("R2 mask readback", regRdData, 8'hC0);

    finished = 1;
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      nChecks++; nFails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule